// File: doc/BRIEF.md
# Buck Converter Protection Sequencer

This block is the digital supervisor of a single-phase synchronous buck controller. It watches a hysteresis-filtered supply-good signal, an active-high enable, three comparator flags (feedback over-voltage, feedback under-voltage, over-current) and a soft-start-done indication from the ramp counter. From these it decides when the gate drivers may switch, when the low-side gate must be forced on, and when the low-side pin must float so the current-limit level can be captured.

Each fault has its own policy. Over-voltage is latched until the supply drops and returns. Under-voltage and over-current both stop switching and retry after a hiccup wait, and the two waits differ. Over-voltage protection still acts while the supply is below its good level. All delays are counted in cycles of `clk`.

Top module: `buck_prot_seq`

## Requirements
- R1: Reset or `supply_ok` low puts the block into the power-off state (mode 0) on the next clock edge, from any state. No switching takes place there. Mode codes: 0 power-off, 1 limit setup, 2 idle, 3 soft-start, 4 run, 5 under-voltage hiccup, 6 over-current hiccup, 7 over-voltage latch.
- R2: When `supply_ok` rises, the block spends exactly SETUP_TICKS cycles in mode 1 with `ls_tristate` and `ocset_win` high and `hs_off` high. It then enters soft-start if `enable` is high, or idle if it is low.
- R3: `sw_en` is high in soft-start and run and low in every other mode. `hs_off` is its inverse. Soft-start moves to run on the first cycle that `ss_done` is high.
- R4: `ov_flag` in soft-start or run enters mode 7 with `low_force` high and `hs_off` high. Mode 7 is left only when `supply_ok` goes low.
- R5: In mode 0, `low_force` follows `ov_flag` in the same cycle.
- R6: `uv_flag` in run enters mode 5 with both gates off for UV_WAIT_TICKS cycles. The block then returns to soft-start, and this repeats while the fault persists.
- R7: `uv_flag` has no effect in soft-start.
- R8: `oc_flag` in soft-start or run enters mode 6 with both gates off for 4×SS_TICKS cycles. The block then returns to soft-start.
- R9: When flags are high in the same cycle, over-voltage wins over over-current, and over-current wins over under-voltage.
- R10: `enable` low in soft-start or run enters idle (mode 2, both gates off). `enable` high in idle goes straight to soft-start without a new setup window.
- R11: A hiccup wait that ends while `enable` is low goes to idle instead of soft-start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timers count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above power-on level (hysteresis applied outside) |
| enable | input | 1 | Active high; low requests shutdown |
| ov_flag | input | 1 | Feedback over-voltage comparator |
| uv_flag | input | 1 | Feedback under-voltage comparator |
| oc_flag | input | 1 | Over-current comparator |
| ss_done | input | 1 | Soft-start ramp has passed the reference |
| mode | output | 3 | Current mode code (see R1) |
| sw_en | output | 1 | Gate drivers may switch |
| low_force | output | 1 | Force the low-side gate on |
| ocset_win | output | 1 | Current-limit capture window open |
| hs_off | output | 1 | Hold the high-side gate off |
| ls_tristate | output | 1 | Float the low-side gate pin |

## Verification
A wrong internal mode shows on `mode` and on the gate controls at the very next sampling point. For this reason the reference model compares every output on every cycle rather than only at checkpoints. Timer faults are the subtle case. An off-by-one in the setup or hiccup count shifts the return to soft-start by a cycle, and the per-cycle comparison sees this in the cycle the mode changes. A lost over-voltage latch would raise `sw_en` while `low_force` should be held, which both the model and an embedded property catch within one cycle.

// File: rtl/buck_prot_seq.sv
module buck_prot_seq #(
  parameter int SETUP_TICKS   = 64,
  parameter int UV_WAIT_TICKS = 40000,
  parameter int SS_TICKS      = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       enable,
  input  logic       ov_flag,
  input  logic       uv_flag,
  input  logic       oc_flag,
  input  logic       ss_done,
  output logic [2:0] mode,
  output logic       sw_en,
  output logic       low_force,
  output logic       ocset_win,
  output logic       hs_off,
  output logic       ls_tristate
);
  localparam int OC_WAIT_TICKS = 4 * SS_TICKS;
  localparam int MAX_A = (SETUP_TICKS > UV_WAIT_TICKS) ? SETUP_TICKS : UV_WAIT_TICKS;
  localparam int MAX_T = (MAX_A > OC_WAIT_TICKS) ? MAX_A : OC_WAIT_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);

  typedef enum logic [2:0] {
    S_OFF = 3'd0, S_SETUP = 3'd1, S_IDLE = 3'd2, S_SOFT = 3'd3,
    S_RUN = 3'd4, S_UVH = 3'd5, S_OCH = 3'd6, S_OVL = 3'd7
  } st_t;

  st_t st, nx;
  logic [CW-1:0] tmr, tmr_nx;

  always_comb begin
    nx     = st;
    tmr_nx = tmr;
    case (st)
      S_OFF:   if (supply_ok) begin nx = S_SETUP; tmr_nx = CW'(SETUP_TICKS - 1); end
      S_SETUP: if (tmr == '0) nx = enable ? S_SOFT : S_IDLE;
               else tmr_nx = tmr - 1'b1;
      S_IDLE:  if (enable) nx = S_SOFT;
      S_SOFT: begin
        if (ov_flag) nx = S_OVL;
        else if (oc_flag) begin nx = S_OCH; tmr_nx = CW'(OC_WAIT_TICKS - 1); end
        else if (!enable) nx = S_IDLE;
        else if (ss_done) nx = S_RUN;
      end
      S_RUN: begin
        if (ov_flag) nx = S_OVL;
        else if (oc_flag) begin nx = S_OCH; tmr_nx = CW'(OC_WAIT_TICKS - 1); end
        else if (uv_flag) begin nx = S_UVH; tmr_nx = CW'(UV_WAIT_TICKS - 1); end
        else if (!enable) nx = S_IDLE;
      end
      S_UVH, S_OCH: if (tmr == '0) nx = enable ? S_SOFT : S_IDLE;
                    else tmr_nx = tmr - 1'b1;
      default: nx = S_OVL;
    endcase
    if (!supply_ok) nx = S_OFF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_OFF;
      tmr <= '0;
    end else begin
      st  <= nx;
      tmr <= tmr_nx;
    end

  assign mode        = st;
  assign sw_en       = (st == S_SOFT) || (st == S_RUN);
  assign hs_off      = !sw_en;
  assign ocset_win   = (st == S_SETUP);
  assign ls_tristate = (st == S_SETUP);
  assign low_force   = (st == S_OVL) || ((st == S_OFF) && ov_flag);

  p_off_on_supply_loss_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (mode == 3'd0));
  p_ov_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7 && supply_ok) |=> (mode == 3'd7));
  p_gates_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> !low_force);
  p_uv_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && supply_ok && enable && !ov_flag && !oc_flag && !ss_done) |=> (mode == 3'd3));
  p_soft_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && $past(mode) != 3'd3) |->
      ($past(mode) == 3'd1 || $past(mode) == 3'd2 || $past(mode) == 3'd5 || $past(mode) == 3'd6));
  p_one_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_en, low_force, ocset_win}));
endmodule

// File: tb/test_buck_prot_seq.sv
module test_buck_prot_seq;
  localparam int SET = 8, UVW = 300, SST = 50, OCW = 4 * SST;

  logic clk = 0, rst_n = 0;
  logic supply_ok = 0, enable = 0, ov = 0, uv = 0, oc = 0, ssd = 0;
  logic [2:0] mode;
  logic sw_en, low_force, ocset_win, hs_off, ls_tristate;
  int checks = 0, errors = 0;
  int m = 0, cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  buck_prot_seq #(.SETUP_TICKS(SET), .UV_WAIT_TICKS(UVW), .SS_TICKS(SST)) i_buck_prot_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .enable(enable),
    .ov_flag(ov), .uv_flag(uv), .oc_flag(oc), .ss_done(ssd),
    .mode(mode), .sw_en(sw_en), .low_force(low_force), .ocset_win(ocset_win),
    .hs_off(hs_off), .ls_tristate(ls_tristate));

  always @(posedge clk) begin
    int nm;
    if (!rst_n) begin m = 0; cnt = 0; end
    else begin
      nm = m;
      if (m == 0 && supply_ok) nm = 1;
      else if (m == 1 && cnt == SET - 1) nm = enable ? 3 : 2;
      else if (m == 2 && enable) nm = 3;
      else if (m == 3 || m == 4) begin
        if (ov) nm = 7;
        else if (oc) nm = 6;
        else if (m == 4 && uv) nm = 5;
        else if (!enable) nm = 2;
        else if (m == 3 && ssd) nm = 4;
      end
      else if (m == 5 && cnt == UVW - 1) nm = enable ? 3 : 2;
      else if (m == 6 && cnt == OCW - 1) nm = enable ? 3 : 2;
      if (!supply_ok) nm = 0;
      cnt = (nm != m) ? 0 : cnt + 1;
      m = nm;
    end
  end

  function automatic string tag_of(int s, logic o);
    case (s)
      0: return o ? "R5" : "R1";
      1: return "R2";
      2: return "R10";
      5: return "R6";
      6: return "R8";
      7: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    string t;
    t = tag_of(m, ov);
    chk(t, "mode", mode, m);
    chk(t, "sw_en", sw_en, (m == 3 || m == 4));
    chk(t, "hs_off", hs_off, !(m == 3 || m == 4));
    chk(t, "low_force", low_force, (m == 7) || (m == 0 && ov));
    chk(t, "ocset_win", ocset_win, m == 1);
    chk(t, "ls_tristate", ls_tristate, m == 1);
  end

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    w(3);
    chk("R1", "reset mode", mode, 0);
    #1 rst_n = 1;
    w(2); #1 ov = 1;
    w(2); chk("R5", "pre-supply low_force", low_force, 1);
    #1 ov = 0; supply_ok = 1; enable = 1;
    w(3); chk("R2", "setup mode", mode, 1);
    chk("R2", "setup tristate", ls_tristate, 1);
    w(20); chk("R3", "soft-start", mode, 3);
    #1 ssd = 1;
    w(3); chk("R3", "run", mode, 4);
    #1 uv = 1; ssd = 0;
    w(5); chk("R6", "uv hiccup", mode, 5);
    w(310); chk("R7", "uv ignored in soft-start", mode, 3);
    w(10); chk("R7", "still soft-start", mode, 3);
    #1 uv = 0; ssd = 1;
    w(3); chk("R3", "run again", mode, 4);
    #1 oc = 1;
    w(3); chk("R8", "oc hiccup", mode, 6);
    #1 oc = 0; ssd = 0;
    w(100); chk("R8", "oc wait holds", mode, 6);
    w(110); chk("R8", "oc retry", mode, 3);
    #1 ssd = 1;
    w(3); chk("R3", "run", mode, 4);
    #1 enable = 0;
    w(3); chk("R10", "idle", mode, 2);
    chk("R10", "idle hs_off", hs_off, 1);
    #1 ssd = 0; enable = 1;
    w(3); chk("R10", "idle to soft-start", mode, 3);
    #1 ssd = 1;
    w(3); #1 oc = 1;
    w(3); #1 oc = 0; enable = 0;
    w(210); chk("R11", "hiccup to idle", mode, 2);
    #1 enable = 1;
    w(3); chk("R3", "run", mode, 4);
    #1 ov = 1; oc = 1; uv = 1;
    w(3); chk("R9", "ov wins", mode, 7);
    chk("R4", "low forced", low_force, 1);
    #1 ov = 0; oc = 0; uv = 0;
    w(50); chk("R4", "ov latched", mode, 7);
    #1 supply_ok = 0;
    w(2); chk("R1", "supply loss", mode, 0);
    #1 supply_ok = 1;
    w(15); chk("R3", "run after repower", mode, 4);
    #1 oc = 1; uv = 1;
    w(3); chk("R9", "oc over uv", mode, 6);
    #1 oc = 0; uv = 0;
    w(210); chk("R3", "back to run", mode, 4);
    #1 supply_ok = 0;
    w(2); chk("R1", "supply loss in run", mode, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule